// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This unit forms the byte-merged result of the four partial-word instructions that let software move a 32-bit word across an arbitrary byte boundary: high-part load, low-part load, high-part store and low-part store. For each request it receives the byte address, the word already fetched from the word-aligned location, and the current contents of the register involved. A load produces the new register value. A store produces the word to write back to the aligned location. Bytes are numbered little-endian, so byte 0 is bits 7:0.

The low address bits select which bytes are taken from memory and which are kept from the register. The unit does not access memory, does not generate addresses beyond clearing the low bits, and does not own the register file. It reports the aligned address, the merged word and a strobe that tells downstream logic whether to write a register or memory.

Both sides use valid/ready. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result sits in a single output register. `in_ready` is high whenever that register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value. Upstream may keep `in_valid` high and change nothing until the request is accepted.

Top module: `uwm_top`

## Requirements
- R1: `out_addr` equals the accepted `in_addr` with its two least significant bits forced to zero.
- R2: Operation code 2'b00 (high-part load) returns `(reg & (0x00FFFFFF >> s)) | (mem << (24 - s))`, where s = 8 × `in_addr[1:0]`. The shifts and masks are truncated to 32 bits. At offset 3 this gives the whole memory word.
- R3: Operation code 2'b01 (low-part load) returns `(reg & (0xFFFFFF00 << (24 - s))) | (mem >> s)`. At offset 0 this gives the whole memory word.
- R4: Operation code 2'b10 (high-part store) returns `(reg >> (24 - s)) | (mem & (0xFFFFFF00 << s))`. At offset 3 this gives the whole register.
- R5: Operation code 2'b11 (low-part store) returns `(reg << s) | (mem & (0x00FFFFFF >> (24 - s)))`. At offset 0 this gives the whole register.
- R6: For a load (`in_op[1]`=0), `out_reg_we` is 1 only when `in_dest` is non-zero. When `in_dest` is 0 the merged word is still presented, but `out_reg_we` is 0. `out_mem_we` is 0 for every load.
- R7: For a store (`in_op[1]`=1), `out_mem_we` is 1 and `out_reg_we` is 0.
- R8: A request accepted on one rising edge appears with `out_valid`=1 right after that same edge.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_data`, `out_addr`, `out_dest` and both strobes stay unchanged.
- R10: While `rst_n`=0, `out_valid`, `out_data`, `out_addr`, `out_dest` and both strobes are 0.
- R11: When `out_valid`=1 and `out_ready`=1, `in_ready` is 1. A request offered in that cycle replaces the delivered result on the same edge, with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 2 | 00 high-part load, 01 low-part load, 10 high-part store, 11 low-part store |
| in_addr | input | 32 | Byte address of the access |
| in_mem_word | input | 32 | Word read from the aligned address |
| in_reg_word | input | 32 | Current register value |
| in_dest | input | 5 | Register index of the load target |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Merged register value or merged store word |
| out_addr | output | 32 | Word-aligned address |
| out_dest | output | 5 | Register index passed through |
| out_reg_we | output | 1 | Write `out_data` to register `out_dest` |
| out_mem_we | output | 1 | Write `out_data` to memory at `out_addr` |

## Verification
Two things can happen on the same edge: the held result is handed to the consumer, and a new request is captured into the same register. The bench provokes this in two ways. First, it stalls the consumer with a request already queued behind the held result, then releases `out_ready`. Second, it streams requests with `in_valid` held high. In both cases it checks that the new merged word appears one cycle later and that the held word is not dropped or repeated. During the stall it also checks that `in_ready` is low and that the held word does not change.

// File: rtl/uwm_pkg.sv
package uwm_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_HI  = 2'b00,
    OP_LOAD_LO  = 2'b01,
    OP_STORE_HI = 2'b10,
    OP_STORE_LO = 2'b11
  } uwm_op_e;

  function automatic logic op_is_store(input uwm_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/uwm_byte_lane.sv
module uwm_byte_lane
  import uwm_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int LANE_IDX = 0,
  parameter int OFS_W    = $clog2(LANES)
) (
  input  uwm_op_e                   op,
  input  logic [OFS_W-1:0]          ofs,
  input  logic [LANES-1:0][7:0]     mem_b,
  input  logic [LANES-1:0][7:0]     reg_b,
  output logic [7:0]                byte_o
);
  localparam int               LAST = LANES - 1;
  localparam logic [OFS_W-1:0] IDX  = OFS_W'(LANE_IDX);
  localparam logic [OFS_W-1:0] ONE  = OFS_W'(1);

  logic             from_mem;
  logic [OFS_W-1:0] sel;

  always_comb begin
    from_mem = 1'b0;
    sel      = IDX;
    unique case (op)
      OP_LOAD_HI: begin
        if (int'(ofs) >= LAST - LANE_IDX) begin
          from_mem = 1'b1;
          sel      = IDX + ofs + ONE;
        end
      end
      OP_LOAD_LO: begin
        if (LANE_IDX + int'(ofs) <= LAST) begin
          from_mem = 1'b1;
          sel      = IDX + ofs;
        end
      end
      OP_STORE_HI: begin
        if (LANE_IDX > int'(ofs)) from_mem = 1'b1;
        else                      sel      = IDX - ofs - ONE;
      end
      default: begin
        if (LANE_IDX < int'(ofs)) from_mem = 1'b1;
        else                      sel      = IDX - ofs;
      end
    endcase
    byte_o = from_mem ? mem_b[sel] : reg_b[sel];
  end
endmodule

// File: rtl/uwm_merge_core.sv
module uwm_merge_core
  import uwm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  uwm_op_e              op,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [DATA_W-1:0]    mem_w,
  input  logic [DATA_W-1:0]    reg_w,
  output logic [DATA_W-1:0]    merged_w
);
  logic [LANES-1:0][7:0] mem_b;
  logic [LANES-1:0][7:0] reg_b;
  logic [LANES-1:0][7:0] res_b;

  assign mem_b    = mem_w;
  assign reg_b    = reg_w;
  assign merged_w = res_b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    uwm_byte_lane #(
      .LANES    (LANES),
      .LANE_IDX (g),
      .OFS_W    (OFS_W)
    ) lane_i (
      .op     (op),
      .ofs    (ofs),
      .mem_b  (mem_b),
      .reg_b  (reg_b),
      .byte_o (res_b[g])
    );
  end
endmodule

// File: rtl/uwm_out_stage.sv
module uwm_out_stage #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_valid,
  output logic              cap_ready,
  input  logic [DATA_W-1:0] cap_data,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [IDX_W-1:0]  cap_dest,
  input  logic              cap_reg_we,
  input  logic              cap_mem_we,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_data,
  output logic [ADDR_W-1:0] q_addr,
  output logic [IDX_W-1:0]  q_dest,
  output logic              q_reg_we,
  output logic              q_mem_we
);
  logic take;

  assign cap_ready = !q_valid || q_ready;
  assign take      = cap_valid && cap_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_data   <= '0;
      q_addr   <= '0;
      q_dest   <= '0;
      q_reg_we <= 1'b0;
      q_mem_we <= 1'b0;
    end else if (take) begin
      q_valid  <= 1'b1;
      q_data   <= cap_data;
      q_addr   <= cap_addr;
      q_dest   <= cap_dest;
      q_reg_we <= cap_reg_we;
      q_mem_we <= cap_mem_we;
    end else if (q_ready) begin
      q_valid  <= 1'b0;
      q_reg_we <= 1'b0;
      q_mem_we <= 1'b0;
    end
  end

  // R8: an accepted request is visible right after the edge
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid && cap_ready |=> q_valid);

  // R9: a stalled result holds still
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid && !q_ready |=> q_valid && $stable(q_data) && $stable(q_addr)
                            && $stable(q_reg_we) && $stable(q_mem_we));

  // R7: register and memory strobes never coincide
  p_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_reg_we && q_mem_we));

  // R6: a strobe is only raised alongside a valid result
  p_we_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_reg_we || q_mem_we) |-> q_valid);
endmodule

// File: rtl/uwm_top.sv
module uwm_top
  import uwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_mem_word,
  input  logic [DATA_W-1:0] in_reg_word,
  input  logic [IDX_W-1:0]  in_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic [IDX_W-1:0]  out_dest,
  output logic              out_reg_we,
  output logic              out_mem_we
);
  uwm_op_e           op;
  logic [OFS_W-1:0]  ofs;
  logic [DATA_W-1:0] merged;
  logic [ADDR_W-1:0] word_addr;
  logic              is_store;
  logic              reg_we_d;
  logic              mem_we_d;

  assign op        = uwm_op_e'(in_op);
  assign ofs       = in_addr[OFS_W-1:0];
  assign word_addr = {in_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign is_store  = op_is_store(op);
  assign reg_we_d  = !is_store && (in_dest != '0);
  assign mem_we_d  = is_store;

  uwm_merge_core #(.DATA_W(DATA_W)) core_i (
    .op       (op),
    .ofs      (ofs),
    .mem_w    (in_mem_word),
    .reg_w    (in_reg_word),
    .merged_w (merged)
  );

  uwm_out_stage #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) stage_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_valid  (in_valid),
    .cap_ready  (in_ready),
    .cap_data   (merged),
    .cap_addr   (word_addr),
    .cap_dest   (in_dest),
    .cap_reg_we (reg_we_d),
    .cap_mem_we (mem_we_d),
    .q_valid    (out_valid),
    .q_ready    (out_ready),
    .q_data     (out_data),
    .q_addr     (out_addr),
    .q_dest     (out_dest),
    .q_reg_we   (out_reg_we),
    .q_mem_we   (out_mem_we)
  );

  // R3: low-part load at offset 0 returns the memory word untouched
  p_lo_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'b01 && in_addr[1:0] == 2'b00
    |=> out_data == $past(in_mem_word));

  // R4: high-part store at offset 3 writes the register untouched
  p_hi_store_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'b10 && in_addr[1:0] == 2'b11
    |=> out_data == $past(in_reg_word));

  // R7: every accepted store raises the memory strobe
  p_store_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[1] |=> out_mem_we && !out_reg_we);

  // R6: a load into index 0 never raises the register strobe
  p_dest_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_op[1] && in_dest == '0 |=> !out_reg_we);
endmodule

// File: tb/uwm_top_tb_top.sv
module uwm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  in_op;
  logic [31:0] in_addr;
  logic [31:0] in_mem_word;
  logic [31:0] in_reg_word;
  logic [4:0]  in_dest;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;
  logic [31:0] out_addr;
  logic [4:0]  out_dest;
  logic        out_reg_we;
  logic        out_mem_we;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [31:0] MEM = 32'h1122_3344;
  localparam logic [31:0] REG = 32'hAABB_CCDD;

  // {op, offset, expected merged word}
  localparam logic [35:0] VEC [16] = '{
    {2'b00, 2'd0, 32'h44BB_CCDD}, {2'b00, 2'd1, 32'h3344_CCDD},
    {2'b00, 2'd2, 32'h2233_44DD}, {2'b00, 2'd3, 32'h1122_3344},
    {2'b01, 2'd0, 32'h1122_3344}, {2'b01, 2'd1, 32'hAA11_2233},
    {2'b01, 2'd2, 32'hAABB_1122}, {2'b01, 2'd3, 32'hAABB_CC11},
    {2'b10, 2'd0, 32'h1122_33AA}, {2'b10, 2'd1, 32'h1122_AABB},
    {2'b10, 2'd2, 32'h11AA_BBCC}, {2'b10, 2'd3, 32'hAABB_CCDD},
    {2'b11, 2'd0, 32'hAABB_CCDD}, {2'b11, 2'd1, 32'hBBCC_DD44},
    {2'b11, 2'd2, 32'hCCDD_3344}, {2'b11, 2'd3, 32'hDD22_3344}
  };

  always #2 clk = ~clk;

  uwm_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_addr(in_addr), .in_mem_word(in_mem_word), .in_reg_word(in_reg_word),
    .in_dest(in_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_addr(out_addr), .out_dest(out_dest),
    .out_reg_we(out_reg_we), .out_mem_we(out_mem_we)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] addr,
                       input logic [31:0] mem, input logic [31:0] rv,
                       input logic [4:0] dest);
    in_valid    = 1'b1;
    in_op       = op;
    in_addr     = addr;
    in_mem_word = mem;
    in_reg_word = rv;
    in_dest     = dest;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    in_op = '0; in_addr = '0; in_mem_word = '0; in_reg_word = '0; in_dest = '0;
    repeat (3) step();
    // R10: reset state
    chk(!out_valid && out_data == 0 && out_addr == 0 && out_dest == 0
        && !out_reg_we && !out_mem_we, "R10 reset", {26'd0, out_valid, out_dest},
        32'd0);
    rst_n = 1'b1;
    step();

    // Table walk: R1..R8
    for (int i = 0; i < 16; i++) begin
      logic [1:0]  op;
      logic [1:0]  o;
      logic [31:0] exp;
      {op, o, exp} = VEC[i];
      drive(op, 32'h0000_1000 | 32'(o), MEM, REG, 5'd5);
      step();
      in_valid = 1'b0;
      chk(out_valid, "R8 valid after accept", {31'd0, out_valid}, 32'd1);
      chk(out_data == exp, op == 2'b00 ? "R2 hi load" : op == 2'b01 ? "R3 lo load" :
          op == 2'b10 ? "R4 hi store" : "R5 lo store", out_data, exp);
      chk(out_addr == 32'h0000_1000, "R1 aligned addr", out_addr, 32'h1000);
      if (op[1])
        chk(out_mem_we && !out_reg_we, "R7 store strobes",
            {30'd0, out_mem_we, out_reg_we}, 32'd2);
      else
        chk(out_reg_we && !out_mem_we && out_dest == 5'd5, "R6 load strobes",
            {30'd0, out_mem_we, out_reg_we}, 32'd1);
    end

    // R1 + R5: top-end address
    drive(2'b11, 32'hFFFF_FFFF, MEM, REG, 5'd7);
    step();
    in_valid = 1'b0;
    chk(out_addr == 32'hFFFF_FFFC, "R1 high addr", out_addr, 32'hFFFF_FFFC);
    chk(out_data == 32'hDD22_3344, "R5 lo store ofs3", out_data, 32'hDD22_3344);

    // R6: load to index 0
    drive(2'b01, 32'h0000_2002, 32'hCAFE_F00D, 32'h0123_4567, 5'd0);
    step();
    in_valid = 1'b0;
    chk(out_valid && !out_reg_we && !out_mem_we, "R6 dest zero no write",
        {30'd0, out_mem_we, out_reg_we}, 32'd0);
    chk(out_data == 32'h0123_CAFE, "R3 lo load ofs2", out_data, 32'h0123_CAFE);
    step();
    chk(!out_valid, "R8 drains when idle", {31'd0, out_valid}, 32'd0);

    // R9 / R11: stall with a request queued, then release
    out_ready = 1'b0;
    drive(2'b00, 32'h0000_3001, MEM, REG, 5'd9);
    step();
    chk(out_valid && out_data == 32'h3344_CCDD, "R2 hi load before stall",
        out_data, 32'h3344_CCDD);
    drive(2'b11, 32'h0000_4002, MEM, REG, 5'd3);
    for (int k = 0; k < 3; k++) begin
      chk(!in_ready, "R9 in_ready low", {31'd0, in_ready}, 32'd0);
      step();
      chk(out_valid && out_data == 32'h3344_CCDD && out_addr == 32'h3000
          && out_reg_we, "R9 held result", out_data, 32'h3344_CCDD);
    end
    out_ready = 1'b1;
    #0;
    chk(in_ready, "R11 ready on drain", {31'd0, in_ready}, 32'd1);
    step();
    in_valid = 1'b0;
    chk(out_valid && out_data == 32'hCCDD_3344 && out_mem_we && out_addr == 32'h4000,
        "R11 replaced on drain edge", out_data, 32'hCCDD_3344);

    // R11: streaming with in_valid held high
    drive(2'b10, 32'h0000_5001, 32'h0A0B_0C0D, 32'h1020_3040, 5'd1);
    step();
    drive(2'b00, 32'h0000_5002, 32'h0A0B_0C0D, 32'h1020_3040, 5'd2);
    chk(out_data == 32'h0A0B_1020, "R4 stream 1", out_data, 32'h0A0B_1020);
    step();
    drive(2'b01, 32'h0000_5003, 32'h0A0B_0C0D, 32'h1020_3040, 5'd4);
    chk(out_data == 32'h0B0C_0D40 && out_dest == 5'd2, "R2 stream 2", out_data,
        32'h0B0C_0D40);
    step();
    in_valid = 1'b0;
    chk(out_data == 32'h1020_300A && out_valid, "R3 stream 3", out_data,
        32'h1020_300A);

    // R10: reset while a result is held
    out_ready = 1'b0;
    rst_n = 1'b0;
    step();
    chk(!out_valid && out_data == 0 && !out_reg_we && !out_mem_we,
        "R10 reset mid-run", out_data, 32'd0);
    rst_n = 1'b1;
    out_ready = 1'b1;
    step();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule